// File: doc/BRIEF.md
# Shared-Adder Integer Add/Subtract Unit

This block is the arithmetic slice of an integer ALU. It is purely combinational. It takes two operands and a two-bit operation code, and it returns a sum or difference together with a zero indication and a signed overflow indication. The operations are signed add, unsigned add, signed subtract and unsigned subtract.

All four operations share one adder. For a subtraction the second operand is inverted bit by bit and the adder carry-in is forced high, so the adder computes A + NOT(B) + 1. The signed and unsigned forms of an operation produce the same result bits. They differ only in whether overflow is reported.

The width is a parameter, 32 by default. The adder structure is chosen by another parameter: a native `+`, a bit-level ripple chain, or a carry-select arrangement with a configurable block size. The carry-select arrangement is the default.

Top module: `addsub_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (signed add), `result` equals (`opnd_a` + `opnd_b`) modulo 2^WIDTH.
- R2: With `op_sel` = 2'b10 (signed subtract), `result` equals (`opnd_a` − `opnd_b`) modulo 2^WIDTH.
- R3: The unsigned codes 2'b01 (add) and 2'b11 (subtract) give exactly the same `result` bits as their signed counterparts 2'b00 and 2'b10.
- R4: Under signed add, `ovf_flag` is 1 exactly when both operands carry the same sign bit (bit WIDTH-1) and the sign bit of `result` differs from it.
- R5: Under signed subtract, `ovf_flag` is 1 exactly when the operand sign bits differ and the sign bit of `result` differs from the sign bit of `opnd_a`.
- R6: Under either unsigned code, `ovf_flag` is always 0, including when the adder produces a carry out of the top bit.
- R7: `zero_flag` is 1 exactly when every bit of `result` is 0, for every code and whatever the value of `ovf_flag`.
- R8: The operation codes are 2'b00 signed add, 2'b01 unsigned add, 2'b10 signed subtract and 2'b11 unsigned subtract. Bit 1 selects subtraction and bit 0 suppresses overflow.
- R9: At WIDTH = 32 the following cases hold. 0x7FFFFFFF + 1 under signed add gives 0x80000000 with overflow. 0x80000000 − 1 under signed subtract gives 0x7FFFFFFF with overflow. 0 − 0x80000000 under signed subtract gives 0x80000000 with overflow. The unsigned codes give the same bits with overflow clear.
- R10: Every output is a combinational function of the present inputs. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend for subtraction) |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | Operation code: bit 1 = subtract, bit 0 = unsigned |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| zero_flag | output | 1 | High when `result` is all zeros |
| ovf_flag | output | 1 | Signed overflow; always low for the unsigned codes |

## Verification
The unit holds no state, so `result`, `zero_flag` and `ovf_flag` are all due in the same cycle as the operands and code that produce them, with no register latency. The bench changes the inputs just after a rising clock edge. It compares all three outputs at the following falling edge, half a period later and well after any zero-delay settling. It does not look at the outputs again until the next stimulus has been applied. Expected values come from exact signed integer arithmetic on a wider type: the true sum or difference is range-checked to decide overflow and then reduced modulo 2^WIDTH. The six-bit instance is swept exhaustively over every operand pair and every code. The three 32-bit adder variants are run on the named corner cases and on a pseudo-random set.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   // Adder structure selectors
   localparam int ADDER_NATIVE = 0;
   localparam int ADDER_RIPPLE = 1;
   localparam int ADDER_CSEL   = 2;

   // Operation codes: bit 1 = subtract, bit 0 = unsigned (no overflow)
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_ADDU = 2'b01,
      OP_SUB  = 2'b10,
      OP_SUBU = 2'b11
   } addsub_op_e;

   typedef struct packed {
      logic inv_b;    // feed NOT(B) into the adder
      logic cin;      // adder carry-in
      logic ovf_en;   // signed overflow reporting enabled
   } addsub_ctl_t;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
   import addsub_pkg::*;
(
   input  logic [1:0]  op_sel,
   output addsub_ctl_t ctl
);

   always_comb begin
      case (addsub_op_e'(op_sel))
         OP_ADD:  ctl = '{inv_b: 1'b0, cin: 1'b0, ovf_en: 1'b1};
         OP_ADDU: ctl = '{inv_b: 1'b0, cin: 1'b0, ovf_en: 1'b0};
         OP_SUB:  ctl = '{inv_b: 1'b1, cin: 1'b1, ovf_en: 1'b1};
         OP_SUBU: ctl = '{inv_b: 1'b1, cin: 1'b1, ovf_en: 1'b0};
         default: ctl = '{inv_b: 1'b0, cin: 1'b0, ovf_en: 1'b0};
      endcase
   end

endmodule

// File: rtl/addsub_operand_mux.sv
module addsub_operand_mux #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             inv_b,
   output logic [WIDTH-1:0] b_eff
);

   if (WIDTH < 1) begin : g_bad_width
      $error("addsub_operand_mux: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign b_eff[i] = inv_b ? ~opnd_b[i] : opnd_b[i];
   end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
   import addsub_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int STYLE = ADDER_CSEL,
   parameter int BLOCK = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum
);

   if (WIDTH < 2) begin : g_bad_width
      $error("addsub_adder: WIDTH must be at least 2");
   end
   if (STYLE != ADDER_NATIVE && STYLE != ADDER_RIPPLE && STYLE != ADDER_CSEL) begin : g_bad_style
      $error("addsub_adder: unknown STYLE");
   end

   if (STYLE == ADDER_NATIVE) begin : g_native
      assign sum = a + b + {{(WIDTH-1){1'b0}}, cin};
   end
   else if (STYLE == ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] cy;   // carry into each bit
      assign cy[0] = cin;
      for (genvar j = 1; j < WIDTH; j++) begin : g_cy
         assign cy[j] = maj3(a[j-1], b[j-1], cy[j-1]);
      end
      for (genvar j = 0; j < WIDTH; j++) begin : g_sum
         assign sum[j] = a[j] ^ b[j] ^ cy[j];
      end
   end
   else begin : g_csel
      localparam int NB = WIDTH / BLOCK;

      if (BLOCK < 1 || (WIDTH % BLOCK) != 0) begin : g_bad_block
         $error("addsub_adder: BLOCK must divide WIDTH");
      end

      logic [NB-1:0] bc;      // carry into each block
      assign bc[0] = cin;

      for (genvar k = 0; k < NB; k++) begin : g_blk
         localparam int BASE = k * BLOCK;
         logic [BLOCK-1:0] c0, c1, s0, s1;

         assign c0[0] = 1'b0;
         assign c1[0] = 1'b1;
         for (genvar j = 1; j < BLOCK; j++) begin : g_cy
            assign c0[j] = maj3(a[BASE+j-1], b[BASE+j-1], c0[j-1]);
            assign c1[j] = maj3(a[BASE+j-1], b[BASE+j-1], c1[j-1]);
         end
         for (genvar j = 0; j < BLOCK; j++) begin : g_sum
            assign s0[j] = a[BASE+j] ^ b[BASE+j] ^ c0[j];
            assign s1[j] = a[BASE+j] ^ b[BASE+j] ^ c1[j];
         end

         assign sum[BASE +: BLOCK] = bc[k] ? s1 : s0;

         if (k < NB - 1) begin : g_next
            logic co0, co1;
            assign co0 = maj3(a[BASE+BLOCK-1], b[BASE+BLOCK-1], c0[BLOCK-1]);
            assign co1 = maj3(a[BASE+BLOCK-1], b[BASE+BLOCK-1], c1[BLOCK-1]);
            assign bc[k+1] = bc[k] ? co1 : co0;
         end
      end
   end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] sum,
   input  logic             a_msb,
   input  logic             beff_msb,
   input  logic             ovf_en,
   output logic             zero_flag,
   output logic             ovf_flag
);

   logic same_in_sign;
   logic sign_flipped;

   // Adder inputs agree in sign but the sum does not: signed overflow.
   assign same_in_sign = ~(a_msb ^ beff_msb);
   assign sign_flipped = sum[WIDTH-1] ^ a_msb;
   assign ovf_flag     = ovf_en & same_in_sign & sign_flipped;

   assign zero_flag    = ~|sum;

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
   import addsub_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = ADDER_CSEL,
   parameter int CSEL_BLOCK  = 8
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             ovf_flag
);

   if (WIDTH < 2) begin : g_bad_width
      $error("addsub_unit: WIDTH must be at least 2");
   end

   addsub_ctl_t      ctl;
   logic [WIDTH-1:0] b_eff;

   addsub_decode u_decode (
      .op_sel (op_sel),
      .ctl    (ctl)
   );

   addsub_operand_mux #(.WIDTH(WIDTH)) u_bmux (
      .opnd_b (opnd_b),
      .inv_b  (ctl.inv_b),
      .b_eff  (b_eff)
   );

   addsub_adder #(
      .WIDTH (WIDTH),
      .STYLE (ADDER_STYLE),
      .BLOCK (CSEL_BLOCK)
   ) u_adder (
      .a   (opnd_a),
      .b   (b_eff),
      .cin (ctl.cin),
      .sum (result)
   );

   addsub_flags #(.WIDTH(WIDTH)) u_flags (
      .sum       (result),
      .a_msb     (opnd_a[WIDTH-1]),
      .beff_msb  (b_eff[WIDTH-1]),
      .ovf_en    (ctl.ovf_en),
      .zero_flag (zero_flag),
      .ovf_flag  (ovf_flag)
   );

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [1:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             zero_flag,
   input logic             ovf_flag
);

   logic sa, sb, sr;
   assign sa = opnd_a[WIDTH-1];
   assign sb = opnd_b[WIDTH-1];
   assign sr = result[WIDTH-1];

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_sel, result, zero_flag, ovf_flag})) begin
         if (op_sel[1] == 1'b0) begin
            // R1
            add_sum_chk: assert (result == WIDTH'(opnd_a + opnd_b))
               else $error("add_sum_chk: sum mismatch");
         end
         else begin
            // R2
            sub_diff_chk: assert (result == WIDTH'(opnd_a - opnd_b))
               else $error("sub_diff_chk: difference mismatch");
         end
         if (op_sel == 2'b00) begin
            // R4
            add_ovf_chk: assert (ovf_flag == ((sa == sb) && (sr != sa)))
               else $error("add_ovf_chk: signed add overflow wrong");
         end
         if (op_sel == 2'b10) begin
            // R5
            sub_ovf_chk: assert (ovf_flag == ((sa != sb) && (sr != sa)))
               else $error("sub_ovf_chk: signed subtract overflow wrong");
         end
         if (op_sel[0]) begin
            // R6
            no_overflow_chk: assert (!ovf_flag)
               else $error("no_overflow_chk: overflow raised on unsigned code");
         end
         // R7
         zero_chk: assert (zero_flag == (result == '0))
            else $error("zero_chk: zero flag disagrees with result");
      end
   end

endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;
   import addsub_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   // 32-bit stimulus shared by three adder variants
   logic [31:0] a32 = '0, b32 = '0;
   logic [1:0]  op32 = 2'b00;
   logic [31:0] r_cs, r_rp, r_nt;
   logic        z_cs, z_rp, z_nt, v_cs, v_rp, v_nt;

   // small exhaustive configuration
   logic [5:0]  a6 = '0, b6 = '0;
   logic [1:0]  op6 = 2'b00;
   logic [5:0]  r6;
   logic        z6, v6;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   addsub_unit #(.WIDTH(32), .ADDER_STYLE(ADDER_CSEL), .CSEL_BLOCK(8)) u_dut (
      .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
      .result(r_cs), .zero_flag(z_cs), .ovf_flag(v_cs));

   addsub_unit #(.WIDTH(32), .ADDER_STYLE(ADDER_RIPPLE), .CSEL_BLOCK(8)) u_rip (
      .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
      .result(r_rp), .zero_flag(z_rp), .ovf_flag(v_rp));

   addsub_unit #(.WIDTH(32), .ADDER_STYLE(ADDER_NATIVE), .CSEL_BLOCK(8)) u_nat (
      .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
      .result(r_nt), .zero_flag(z_nt), .ovf_flag(v_nt));

   addsub_unit #(.WIDTH(6), .ADDER_STYLE(ADDER_CSEL), .CSEL_BLOCK(2)) u_small (
      .opnd_a(a6), .opnd_b(b6), .op_sel(op6),
      .result(r6), .zero_flag(z6), .ovf_flag(v6));

   // Exact signed arithmetic model; codes per R8.
   function automatic void model(input int w, input longint unsigned a,
                                 input longint unsigned b, input logic [1:0] op,
                                 output longint unsigned res, output bit z, output bit v);
      longint sa, sb, ex, lim;
      longint unsigned mask;
      lim  = longint'(1) <<< (w - 1);
      mask = (longint'(1) <<< w) - 1;
      sa = a[w-1] ? longint'(a) - (lim * 2) : longint'(a);
      sb = b[w-1] ? longint'(b) - (lim * 2) : longint'(b);
      ex = op[1] ? (sa - sb) : (sa + sb);
      res = longint'(ex) & mask;
      v   = !op[0] && ((ex >= lim) || (ex < -lim));
      z   = (res == 0);
   endfunction

   function automatic string tag_of(input logic [1:0] op);
      case (op)
         2'b00:   return "R1 R4 R7 R8";
         2'b01:   return "R3 R6 R7 R8";
         2'b10:   return "R2 R5 R7 R8";
         default: return "R3 R6 R7 R8";
      endcase
   endfunction

   task automatic check(input string tag, input string who,
                        input longint unsigned gr, input bit gz, input bit gv,
                        input longint unsigned er, input bit ez, input bit ev);
      n_vec++;
      if (gr != er || gz != ez || gv != ev) begin
         n_bad++;
         $display("FAIL %s [%s]: result=%h zero=%b ovf=%b expected result=%h zero=%b ovf=%b",
                  tag, who, gr, gz, gv, er, ez, ev);
      end
   endtask

   // Drive just after a rising edge, sample at the following falling edge (R10).
   task automatic apply32(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] op, input string extra);
      longint unsigned er;
      bit ez, ev;
      string t;
      @(posedge clk);
      #1;
      a32 = a; b32 = b; op32 = op;
      @(negedge clk);
      model(32, a, b, op, er, ez, ev);
      t = {extra, " ", tag_of(op)};
      check(t, "cselect", r_cs, z_cs, v_cs, er, ez, ev);
      check(t, "ripple",  r_rp, z_rp, v_rp, er, ez, ev);
      check(t, "native",  r_nt, z_nt, v_nt, er, ez, ev);
   endtask

   task automatic apply6(input logic [5:0] a, input logic [5:0] b, input logic [1:0] op);
      longint unsigned er;
      bit ez, ev;
      @(posedge clk);
      #1;
      a6 = a; b6 = b; op6 = op;
      @(negedge clk);
      model(6, a, b, op, er, ez, ev);
      check({"sweep ", tag_of(op)}, "w6", r6, z6, v6, er, ez, ev);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      logic [31:0] seed;
      // Idle state: all-zero inputs give zero result, zero set, no overflow (R7, R10)
      @(negedge clk);
      check("R7 R10 idle", "cselect", r_cs, z_cs, v_cs, 0, 1'b1, 1'b0);

      // R9 named boundary cases, each under all four codes
      for (int op = 0; op < 4; op++) begin
         apply32(32'h7FFF_FFFF, 32'h0000_0001, 2'(op), "R9 maxpos+1");
         apply32(32'h8000_0000, 32'h0000_0001, 2'(op), "R9 minneg-1");
         apply32(32'h0000_0000, 32'h8000_0000, 2'(op), "R9 0-minneg");
         apply32(32'h8000_0000, 32'h8000_0000, 2'(op), "R7 zero-with-ovf");
         apply32(32'hFFFF_FFFF, 32'h0000_0001, 2'(op), "R6 carry-out");
         apply32(32'h0000_0005, 32'h0000_0005, 2'(op), "R7 equal");
         apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'(op), "R3 allones");
         apply32(32'h0000_0000, 32'h0000_0001, 2'(op), "R2 borrow");
      end

      // Walking single-bit operands
      for (int i = 0; i < 32; i++) begin
         for (int op = 0; op < 4; op++) begin
            apply32(32'h1 << i, 32'h8000_0000 >> i, 2'(op), "walk");
         end
      end

      // Pseudo-random operands
      seed = 32'h1357_9BDF;
      for (int n = 0; n < 2000; n++) begin
         logic [31:0] ra, rb;
         seed = seed * 32'd1664525 + 32'd1013904223;
         ra = seed;
         seed = seed * 32'd1664525 + 32'd1013904223;
         rb = seed;
         for (int op = 0; op < 4; op++) begin
            apply32(ra, rb, 2'(op), "random");
         end
      end

      // Exhaustive six-bit sweep
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            for (int op = 0; op < 4; op++) begin
               apply6(6'(a), 6'(b), 2'(op));
            end
         end
      end

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

endmodule